// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the command side of a byte-wide parallel NOR flash on a simple synchronous bus. The bus has a read strobe, a write strobe, an address, write data and registered read data. Writes are not stored straight into the array. A state machine reads them as a command stream. It recognises a two-write unlock, then an opcode that selects identification readout, a single-byte program, a chip erase or a sector erase. A dedicated reset command returns it to plain array reads.

Program and erase take effect at the clock edge of the final command write. To mimic a real part finishing its work, the block then answers a fixed number of reads with status words instead of array data. During program status, bit 7 is the inverse of the stored bit 7. During erase status, bit 3 is set. In both cases bit 6 flips from one read to the next. After that count, normal array reads return. Storage is an internal byte array of parameterised size. Reset initialises it to the erased value 0xFF.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode with `busy` low, `rdata` is 0x00 and every populated byte reads 0xFF.
- R2: A read in array-read mode returns, one cycle later on `rdata`, the byte at `addr`. Addresses at or above `POP_BYTES` return 0xFF.
- R3: Writing 0xF0 at any address returns the block to array-read mode from every state except an armed program, where 0xF0 is taken as data.
- R4: Unlock is 0xAA written at 0x5555, then 0x55 at 0x2AAA, compared on the low 16 address bits. A write of 0xAA at 0x5555 restarts the unlock when the block is in array-read mode or either unlock step.
- R5: After unlock, 0x90 at 0x5555 enters identification mode. There, reads whose low address byte is 0, 1 or 2 return `MFG_ID`, `DEV_ID` and 0x00. Any other low byte returns 0xFF. Reads do not leave this mode.
- R6: After unlock, 0xA0 at 0x5555 arms a program. The next write overwrites the addressed byte with its data. A target at or above `POP_BYTES` leaves the array unchanged.
- R7: After a program, the next `STATUS_READS` reads return {~stored bit 7, toggle, 6'b0} for the addressed byte. The toggle is 0 on the first read and flips on each read. Array reads then resume.
- R8: Unlock, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, then 0x10 at 0x5555 sets every byte to 0xFF.
- R9: The same six-write prefix ending in 0x30 at any address sets to 0xFF only the sector that contains that address. The sector size is `SECT_SMALL` bytes when `DEV_ID` is 0x20 and `SECT_LARGE` bytes otherwise.
- R10: After an erase, the next `STATUS_READS` reads return 0x08 with bit 6 as the toggle, starting at 0. Array reads then resume.
- R11: A write that does not advance the command sequence, including any write during a status phase, returns the block to array-read mode and leaves the array unchanged.
- R12: A read while in an unlock, erase-prefix or armed-program state returns array data and puts the block back in array-read mode.
- R13: `busy` is high exactly when the block is not in array-read mode.
- R14: When `rd_en` and `wr_en` are high together, the write is processed, the read is ignored and `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Read result, valid the cycle after `rd_en` |
| busy | output | 1 | High when not in array-read mode |

## Verification
The directed cases cover several corners. 0xF0 written to an armed program must be stored, not treated as a reset; a design that tests for the reset code first would leave the old byte in place. A sector erase must spare its neighbours on both sides; a wrong sector mask would wipe them or miss part of the sector. The status count is checked at its last read and the read after it, which exposes an off-by-one that returns status once too often or array data once too early. Bit 6 is checked from the first status read, which catches a toggle that starts in the wrong phase. Randomised command streams aimed at the two unlock addresses exercise restarts, aborted prefixes and reads in the middle of a sequence. A design that drops or keeps state wrongly in those cases then returns array data where status is due, or the reverse.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        FS_ARRAY,
        FS_UNLK1,
        FS_UNLK2,
        FS_IDENT,
        FS_ERS1,
        FS_ERS2,
        FS_ERS3,
        FS_PGM_ARM,
        FS_PGM_STAT,
        FS_ERS_STAT
    } fseq_state_e;

    typedef enum logic [1:0] {
        RSEL_ARRAY,
        RSEL_IDENT,
        RSEL_PGM,
        RSEL_ERS
    } rsel_e;

    localparam logic [15:0] CMD_ADDR_A = 16'h5555;
    localparam logic [15:0] CMD_ADDR_B = 16'h2AAA;

    localparam logic [7:0] OP_KEY1   = 8'hAA;
    localparam logic [7:0] OP_KEY2   = 8'h55;
    localparam logic [7:0] OP_IDENT  = 8'h90;
    localparam logic [7:0] OP_PGM    = 8'hA0;
    localparam logic [7:0] OP_ERS    = 8'h80;
    localparam logic [7:0] OP_CHIP   = 8'h10;
    localparam logic [7:0] OP_SECT   = 8'h30;
    localparam logic [7:0] OP_RESET  = 8'hF0;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int STATUS_READS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_i,
    input  logic        wr_i,
    input  logic [15:0] addr_lo_i,
    input  logic [7:0]  wdata_i,
    output logic        busy_o,
    output rsel_e       rsel_o,
    output logic        tgl_o,
    output logic        pgm_we_o,
    output logic        erase_all_o,
    output logic        erase_sect_o
);

    localparam int CNT_W = $clog2(STATUS_READS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STATUS_READS - 1);

    typedef struct packed {
        fseq_state_e      state;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic at_a, at_b, status_st, pre_cmd_st;

    always_comb begin
        at_a       = (addr_lo_i == CMD_ADDR_A);
        at_b       = (addr_lo_i == CMD_ADDR_B);
        status_st  = (ctrl_q.state == FS_PGM_STAT) || (ctrl_q.state == FS_ERS_STAT);
        pre_cmd_st = (ctrl_q.state inside {FS_UNLK1, FS_UNLK2, FS_ERS1, FS_ERS2,
                                           FS_ERS3, FS_PGM_ARM});
    end

    always_comb begin
        ctrl_d       = ctrl_q;
        pgm_we_o     = 1'b0;
        erase_all_o  = 1'b0;
        erase_sect_o = 1'b0;
        tgl_o        = ctrl_q.cnt[0];

        case (ctrl_q.state)
            FS_IDENT:    rsel_o = RSEL_IDENT;
            FS_PGM_STAT: rsel_o = RSEL_PGM;
            FS_ERS_STAT: rsel_o = RSEL_ERS;
            default:     rsel_o = RSEL_ARRAY;
        endcase

        if (wr_i) begin
            if (ctrl_q.state == FS_PGM_ARM) begin
                pgm_we_o     = 1'b1;
                ctrl_d.state = FS_PGM_STAT;
                ctrl_d.cnt   = '0;
            end else if (status_st || wdata_i == OP_RESET) begin
                ctrl_d.state = FS_ARRAY;
            end else if (at_a && wdata_i == OP_KEY1 &&
                         ctrl_q.state inside {FS_ARRAY, FS_UNLK1, FS_UNLK2}) begin
                ctrl_d.state = FS_UNLK1;
            end else if (ctrl_q.state == FS_UNLK1 && at_b && wdata_i == OP_KEY2) begin
                ctrl_d.state = FS_UNLK2;
            end else if (ctrl_q.state == FS_UNLK2 && at_a && wdata_i == OP_IDENT) begin
                ctrl_d.state = FS_IDENT;
            end else if (ctrl_q.state == FS_UNLK2 && at_a && wdata_i == OP_PGM) begin
                ctrl_d.state = FS_PGM_ARM;
            end else if (ctrl_q.state == FS_UNLK2 && at_a && wdata_i == OP_ERS) begin
                ctrl_d.state = FS_ERS1;
            end else if (ctrl_q.state == FS_ERS1 && at_a && wdata_i == OP_KEY1) begin
                ctrl_d.state = FS_ERS2;
            end else if (ctrl_q.state == FS_ERS2 && at_b && wdata_i == OP_KEY2) begin
                ctrl_d.state = FS_ERS3;
            end else if (ctrl_q.state == FS_ERS3 && at_a && wdata_i == OP_CHIP) begin
                erase_all_o  = 1'b1;
                ctrl_d.state = FS_ERS_STAT;
                ctrl_d.cnt   = '0;
            end else if (ctrl_q.state == FS_ERS3 && wdata_i == OP_SECT) begin
                erase_sect_o = 1'b1;
                ctrl_d.state = FS_ERS_STAT;
                ctrl_d.cnt   = '0;
            end else begin
                ctrl_d.state = FS_ARRAY;
            end
        end else if (rd_i) begin
            if (status_st) begin
                if (ctrl_q.cnt == CNT_LAST) begin
                    ctrl_d.state = FS_ARRAY;
                    ctrl_d.cnt   = '0;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end else if (pre_cmd_st) begin
                ctrl_d.state = FS_ARRAY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.state <= FS_ARRAY;
            ctrl_q.cnt   <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy_o = (ctrl_q.state != FS_ARRAY);

    // R3
    reset_cmd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i == OP_RESET && ctrl_q.state != FS_PGM_ARM) |=> !busy_o);

    // R12
    precmd_read_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i && pre_cmd_st) |=> (ctrl_q.state == FS_ARRAY));

    // R7
    status_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_st |-> (ctrl_q.cnt < CNT_W'(STATUS_READS)));

    // R6
    arm_to_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ctrl_q.state == FS_PGM_ARM) |=> (rsel_o == RSEL_PGM && !tgl_o));

endmodule

// File: rtl/flash_store.sv
module flash_store #(
    parameter int ADDR_W    = 16,
    parameter int POP_BYTES = 512,
    parameter int SECT_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              pgm_we_i,
    input  logic              erase_all_i,
    input  logic              erase_sect_i,
    output logic [7:0]        rbyte_o
);

    localparam int IDX_W = $clog2(POP_BYTES);

    logic [7:0]       mem_q [POP_BYTES];
    logic [7:0]       mem_d [POP_BYTES];
    logic             in_range;
    logic [IDX_W-1:0] idx;

    assign in_range = ({1'b0, addr_i} < (ADDR_W+1)'(POP_BYTES));
    assign idx      = addr_i[IDX_W-1:0];
    assign rbyte_o  = in_range ? mem_q[idx] : 8'hFF;

    for (genvar i = 0; i < POP_BYTES; i++) begin : g_byte
        localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(i);
        logic sect_hit;

        always_comb begin
            sect_hit = ((addr_i >> SECT_W) == (BYTE_ADDR >> SECT_W));
            mem_d[i] = mem_q[i];
            if (erase_all_i || (erase_sect_i && sect_hit)) begin
                mem_d[i] = 8'hFF;
            end else if (pgm_we_i && in_range && idx == IDX_W'(i)) begin
                mem_d[i] = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= 8'hFF;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // R8
    chip_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all_i |=> (mem_q[0] == 8'hFF && mem_q[POP_BYTES-1] == 8'hFF));

    // R6
    pgm_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_we_i && in_range) |=> (mem_q[$past(idx)] == $past(wdata_i)));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int         ADDR_W       = 16,
    parameter int         POP_BYTES    = 512,
    parameter logic [7:0] MFG_ID       = 8'hC2,
    parameter logic [7:0] DEV_ID       = 8'h20,
    parameter int         SECT_SMALL   = 64,
    parameter int         SECT_LARGE   = 256,
    parameter int         STATUS_READS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy
);

    localparam int SECT_BYTES = (DEV_ID == 8'h20) ? SECT_SMALL : SECT_LARGE;
    localparam int SECT_W     = $clog2(SECT_BYTES);

    rsel_e      rsel;
    logic       tgl;
    logic       pgm_we, erase_all, erase_sect;
    logic [7:0] rbyte;
    logic [7:0] rdata_d, rdata_q;

    flash_seq_ctrl #(
        .STATUS_READS (STATUS_READS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_i         (rd_en),
        .wr_i         (wr_en),
        .addr_lo_i    (addr[15:0]),
        .wdata_i      (wdata),
        .busy_o       (busy),
        .rsel_o       (rsel),
        .tgl_o        (tgl),
        .pgm_we_o     (pgm_we),
        .erase_all_o  (erase_all),
        .erase_sect_o (erase_sect)
    );

    flash_store #(
        .ADDR_W    (ADDR_W),
        .POP_BYTES (POP_BYTES),
        .SECT_W    (SECT_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .pgm_we_i     (pgm_we),
        .erase_all_i  (erase_all),
        .erase_sect_i (erase_sect),
        .rbyte_o      (rbyte)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en && !wr_en) begin
            case (rsel)
                RSEL_IDENT: begin
                    case (addr[7:0])
                        8'h00:   rdata_d = MFG_ID;
                        8'h01:   rdata_d = DEV_ID;
                        8'h02:   rdata_d = 8'h00;
                        default: rdata_d = 8'hFF;
                    endcase
                end
                RSEL_PGM: rdata_d = {~rbyte[7], tgl, 6'b0};
                RSEL_ERS: rdata_d = {1'b0, tgl, 2'b0, 1'b1, 3'b0};
                default:  rdata_d = rbyte;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= 8'h00;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R10
    ers_status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && rsel == RSEL_ERS) |=> (rdata[3] && !rdata[7] && rdata[2:0] == 3'b0));

    // R14
    rdwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> $stable(rdata));

    // R2
    oob_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && rsel == RSEL_ARRAY &&
         ({1'b0, addr} >= (ADDR_W+1)'(POP_BYTES))) |=> (rdata == 8'hFF));

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int POP        = 512;
    localparam int SECT       = 64;
    localparam int NSTAT      = 10;
    localparam logic [7:0] MFG = 8'hC2;
    localparam logic [7:0] DEV = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    // bench reference state: 0 array,1 unl1,2 unl2,3 ident,4..6 erase prefix,
    // 7 armed,8 program status,9 erase status
    int         mst = 0;
    int         mcnt = 0;
    logic [7:0] mmem [POP];
    logic [7:0] last_rd = 8'h00;
    string      tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(
        .ADDR_W(16), .POP_BYTES(POP), .MFG_ID(MFG), .DEV_ID(DEV),
        .SECT_SMALL(SECT), .SECT_LARGE(256), .STATUS_READS(NSTAT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        return (a < POP) ? mmem[a] : 8'hFF;
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (mst == 7) begin
            if (a < POP) mmem[a] = d;
            mst = 8; mcnt = 0;
        end else if (mst == 8 || mst == 9 || d == 8'hF0) begin
            mst = 0;
        end else if (a == 16'h5555 && d == 8'hAA && mst <= 2) mst = 1;
        else if (mst == 1 && a == 16'h2AAA && d == 8'h55) mst = 2;
        else if (mst == 2 && a == 16'h5555 && d == 8'h90) mst = 3;
        else if (mst == 2 && a == 16'h5555 && d == 8'hA0) mst = 7;
        else if (mst == 2 && a == 16'h5555 && d == 8'h80) mst = 4;
        else if (mst == 4 && a == 16'h5555 && d == 8'hAA) mst = 5;
        else if (mst == 5 && a == 16'h2AAA && d == 8'h55) mst = 6;
        else if (mst == 6 && a == 16'h5555 && d == 8'h10) begin
            for (int i = 0; i < POP; i++) mmem[i] = 8'hFF;
            mst = 9; mcnt = 0;
        end else if (mst == 6 && d == 8'h30) begin
            for (int i = 0; i < POP; i++)
                if ((i / SECT) == (int'(a) / SECT)) mmem[i] = 8'hFF;
            mst = 9; mcnt = 0;
        end else mst = 0;
    endtask

    task automatic model_read(input logic [15:0] a, output logic [7:0] e);
        if (mst == 3) begin
            tag = "R5";
            case (a[7:0])
                8'h00: e = MFG;
                8'h01: e = DEV;
                8'h02: e = 8'h00;
                default: e = 8'hFF;
            endcase
        end else if (mst == 8 || mst == 9) begin
            tag = (mst == 8) ? "R7" : "R10";
            e = (mst == 8) ? {~mbyte(a)[7], mcnt[0], 6'b0} : {1'b0, mcnt[0], 6'b001000};
            mcnt++;
            if (mcnt == NSTAT) begin mst = 0; mcnt = 0; end
        end else begin
            tag = (mst == 0) ? "R2" : "R12";
            mst = 0;
            e = mbyte(a);
        end
    endtask

    task automatic op(input bit r, input bit w, input logic [15:0] a, input logic [7:0] d);
        logic [7:0] e;
        e = 8'h00;
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wdata = d;
        if (w) model_write(a, d);
        else if (r) model_read(a, e);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        if (r && !w) begin
            check(tag, rdata, e);
            last_rd = e;
        end else if (r && w) begin
            check("R14", rdata, last_rd);
        end
        check("R13", {7'b0, busy}, {7'b0, (mst != 0)});
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        op(1'b0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [15:0] a);
        op(1'b1, 1'b0, a, 8'h00);
    endtask

    task automatic unlock();
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(16'h5555, 8'h80);
        unlock();
    endtask

    task automatic program_byte(input logic [15:0] a, input logic [7:0] d);
        unlock();
        wr(16'h5555, 8'hA0);
        wr(a, d);
    endtask

    function automatic logic [15:0] pick_addr();
        case ($urandom % 5)
            0, 1: return 16'h5555;
            2:    return 16'h2AAA;
            3:    return 16'($urandom % 640);
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [7:0] pick_data();
        case ($urandom % 12)
            0, 1: return 8'hAA;
            2, 3: return 8'h55;
            4: return 8'h90;
            5: return 8'hA0;
            6: return 8'h80;
            7: return 8'h10;
            8: return 8'h30;
            9: return 8'hF0;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < POP; i++) mmem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", rdata, 8'h00);
        check("R1", {7'b0, busy}, 8'h00);
        rd(16'h0000);
        check("R1", rdata, 8'hFF);
        rd(16'(POP - 1));
        rd(16'(POP));           // R2 beyond populated

        // R5 identification
        unlock();
        wr(16'h5555, 8'h90);
        rd(16'h0000); check("R5", rdata, MFG);
        rd(16'h0301); check("R5", rdata, DEV);
        rd(16'h0002); rd(16'h0007);
        wr(16'h1234, 8'hF0);    // R3
        check("R3", {7'b0, busy}, 8'h00);

        // R6/R7 program, status count
        program_byte(16'h0012, 8'h3C);
        for (int k = 0; k < NSTAT; k++) rd(16'h0012);
        rd(16'h0012); check("R6", rdata, 8'h3C);
        program_byte(16'h0013, 8'h85);
        rd(16'h0013); check("R7", rdata, 8'h00);
        rd(16'h0013); check("R7", rdata, 8'h40);
        wr(16'h0000, 8'h00);    // R11 write during status ends it
        check("R11", {7'b0, busy}, 8'h00);
        rd(16'h0013); check("R6", rdata, 8'h85);
        program_byte(16'h0020, 8'hF0);   // R3 reset code taken as data
        wr(16'h0000, 8'hF0);
        rd(16'h0020); check("R3", rdata, 8'hF0);
        program_byte(16'h0300, 8'h11);   // R6 out of range ignored
        wr(16'h0000, 8'hF0);
        rd(16'h0300); check("R6", rdata, 8'hFF);

        // R11 non-advancing write
        unlock();
        wr(16'h5555, 8'h77);
        check("R11", {7'b0, busy}, 8'h00);
        rd(16'h0012); check("R11", rdata, 8'h3C);

        // R12 read mid-sequence
        wr(16'h5555, 8'hAA);
        rd(16'h0013); check("R12", rdata, 8'h85);
        check("R12", {7'b0, busy}, 8'h00);

        // R4 restart of unlock
        wr(16'h5555, 8'hAA);
        wr(16'h5555, 8'hAA);
        unlock();
        wr(16'h5555, 8'h90);
        rd(16'h0001); check("R4", rdata, DEV);
        wr(16'h0000, 8'hF0);

        // R9 sector erase of second sector
        program_byte(16'h003F, 8'h01); wr(16'h0, 8'hF0);
        program_byte(16'h0040, 8'h02); wr(16'h0, 8'hF0);
        program_byte(16'h007F, 8'h03); wr(16'h0, 8'hF0);
        program_byte(16'h0080, 8'h04); wr(16'h0, 8'hF0);
        erase_prefix();
        wr(16'h0055, 8'h30);
        rd(16'h0040); check("R10", rdata, 8'h08);
        for (int k = 1; k < NSTAT; k++) rd(16'h0040);
        rd(16'h0040); check("R9", rdata, 8'hFF);
        rd(16'h007F); check("R9", rdata, 8'hFF);
        rd(16'h003F); check("R9", rdata, 8'h01);
        rd(16'h0080); check("R9", rdata, 8'h04);

        // R8 chip erase
        erase_prefix();
        wr(16'h5555, 8'h10);
        wr(16'h0, 8'hF0);
        rd(16'h003F); check("R8", rdata, 8'hFF);
        rd(16'h0012); check("R8", rdata, 8'hFF);

        // R14 simultaneous strobes
        program_byte(16'h0005, 8'h5A); wr(16'h0, 8'hF0);
        rd(16'h0005);
        op(1'b1, 1'b1, 16'h5555, 8'hAA);
        check("R14", rdata, 8'h5A);
        wr(16'h0, 8'hF0);

        // randomised command streams
        for (int n = 0; n < 5000; n++) begin
            int sel;
            sel = int'($urandom % 8);
            if (sel < 3) rd(pick_addr());
            else if (sel == 7) op(1'b1, 1'b1, pick_addr(), pick_data());
            else wr(pick_addr(), pick_data());
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule